// File: doc/BRIEF.md
# Key-Gated Serial Programming Entry Detector

This block watches three pins of a two-wire serial debug port: a serial clock, a serial data line and an active-low target reset line. It decides when the device may enter program/verify mode. The entry sequence has three steps. First the reset line gives a short high pulse and returns low. Next, while reset stays low, a 32-bit unlock word is shifted in on the data line, one bit per rising serial clock edge, most significant bit first. Finally reset is released high and held there.

If the shifted word equals 0x4D434850, the block counts a fixed settle interval of system clock cycles after it sees reset go high. Only then does it raise `prog_active` and force unused I/O to high impedance. In this mode each later rising serial clock edge delivers one data bit downstream. If reset drops at any time, the mode ends. A separate four-wire select input grants the mode directly, with no key.

All pins are synchronised into the system clock domain with a two-stage synchroniser and edge detection. The synchronous, active-high system reset clears every state.

Top module: `keygate_entry`

## Requirements
- R1: After system reset, `prog_active`, `hiz_en` and `dat_strobe` are all 0.
- R2: A high-then-low pulse on `tgt_rst_n`, then exactly the 32 bits of 0x4D434850 sent MSB first (bit 31 first) on rising `ser_clk` edges, then `tgt_rst_n` held high, makes `prog_active` 1.
- R3: Any other 32-bit word leaves `prog_active` at 0. This includes a single flipped bit, a flipped MSB and the correct key sent LSB first.
- R4: Without the preceding high-then-low pulse on `tgt_rst_n`, a correct key does not enable the mode.
- R5: After `tgt_rst_n` rises following a good key, `prog_active` stays 0 for at least SETTLE_CYC system cycles and is 1 within a few cycles after that.
- R6: Serial clock edges during the settle interval produce no `dat_strobe`. While the mode is active, each rising `ser_clk` edge produces exactly one `dat_strobe` pulse, with `dat_bit` equal to `ser_dat`.
- R7: A falling `tgt_rst_n` clears `prog_active` and returns to idle. Raising `tgt_rst_n` again without the full sequence does not re-enter the mode.
- R8: `hiz_en` is 1 exactly when `prog_active` is 1.
- R9: While `wire4_sel` is 1, `prog_active` is 1 and data strobes are delivered, with no key.
- R10: Raising `tgt_rst_n` after fewer than 32 key bits aborts the entry. The mode is not entered.
- R11: Extra `ser_clk` edges after the 32nd key bit, before `tgt_rst_n` rises, are ignored. A correct key still enters the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| tgt_rst_n | input | 1 | Active-low target reset pin (asynchronous) |
| ser_clk | input | 1 | Serial debug clock pin (asynchronous) |
| ser_dat | input | 1 | Serial debug data pin (asynchronous) |
| wire4_sel | input | 1 | Four-wire method select; grants mode without key |
| prog_active | output | 1 | Program/verify mode active |
| hiz_en | output | 1 | Force unused I/O to high impedance |
| dat_strobe | output | 1 | One-cycle pulse per accepted serial data bit |
| dat_bit | output | 1 | Value of the accepted serial data bit |

## Verification
A pin change passes two synchroniser stages and reaches the state register on the third system edge. The registered outputs change on that same edge. After a rise on `tgt_rst_n`, `prog_active` is therefore due SETTLE_CYC edges after that third edge. The bench samples 1 ns after a clock edge. It checks `prog_active` low at SETTLE_CYC+1 edges after the pin change and high at SETTLE_CYC+4, so the window is bounded on both sides. Checks on key outcomes, reset drops and strobes wait at least six edges after the stimulus, which is well past the three-edge latency. Strobes are counted on every clock edge, so each serial bit is checked for exactly one pulse.

// File: rtl/keygate_pkg.sv
package keygate_pkg;
  localparam int unsigned KEY_BITS = 32;
  localparam logic [KEY_BITS-1:0] UNLOCK_WORD = 32'h4D43_4850;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SHIFT,
    ST_KEYOK,
    ST_SETTLE,
    ST_ACTIVE
  } entry_state_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g > 0) ? g-1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= chain[STAGES-1];
  end

  assign dout = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/key_shift.sv
module key_shift #(
  parameter int KEY_W = 32,
  parameter logic [KEY_W-1:0] KEY_VAL = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       en,
  input  logic                       bit_in,
  output logic                       full,
  output logic                       match,
  output logic [$clog2(KEY_W+1)-1:0] cnt
);
  localparam int CW = $clog2(KEY_W+1);
  localparam logic [CW-1:0] LAST = CW'(KEY_W);

  logic [KEY_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (en && cnt != LAST) begin
      sreg <= {sreg[KEY_W-2:0], bit_in};
      cnt  <= cnt + 1'b1;
    end
  end

  assign full  = (cnt == LAST);
  assign match = full && (sreg == KEY_VAL);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int TW = $clog2(CYC+1);
  localparam logic [TW-1:0] END_VAL = TW'(CYC-1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != END_VAL) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == END_VAL);
endmodule

// File: rtl/keygate_entry.sv
module keygate_entry
  import keygate_pkg::*;
#(
  parameter int KEY_W = keygate_pkg::KEY_BITS,
  parameter logic [KEY_W-1:0] KEY_VAL = keygate_pkg::UNLOCK_WORD,
  parameter int SETTLE_CYC = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgt_rst_n,
  input  logic ser_clk,
  input  logic ser_dat,
  input  logic wire4_sel,
  output logic prog_active,
  output logic hiz_en,
  output logic dat_strobe,
  output logic dat_bit
);
  localparam int NPIN = 4;
  localparam int P_RST = 0;
  localparam int P_CLK = 1;
  localparam int P_DAT = 2;
  localparam int P_W4  = 3;
  localparam int CW = $clog2(KEY_W+1);

  logic [NPIN-1:0] pins, pin_s, pin_r, pin_f;
  logic pin_rise, pin_fall, sclk_rise, dat_s, w4;

  assign pins = {wire4_sel, ser_dat, ser_clk, tgt_rst_n};

  pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pins),
    .dout(pin_s), .rise(pin_r), .fall(pin_f)
  );

  assign pin_rise  = pin_r[P_RST];
  assign pin_fall  = pin_f[P_RST];
  assign sclk_rise = pin_r[P_CLK];
  assign dat_s     = pin_s[P_DAT];
  assign w4        = pin_s[P_W4];

  entry_state_t state, nxt;
  logic key_full, key_match, tmr_done;
  logic [CW-1:0] key_cnt;

  key_shift #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_shift (
    .clk(clk), .rst(rst),
    .clr(state != ST_SHIFT),
    .en(state == ST_SHIFT && sclk_rise),
    .bit_in(dat_s),
    .full(key_full), .match(key_match), .cnt(key_cnt)
  );

  settle_timer #(.CYC(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst(rst),
    .run(state == ST_SETTLE && !pin_fall),
    .done(tmr_done)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (pin_rise) nxt = ST_ARM;
      ST_ARM:    if (pin_fall) nxt = ST_SHIFT;
      ST_SHIFT: begin
        if (pin_rise)      nxt = ST_ARM;
        else if (key_full) nxt = key_match ? ST_KEYOK : ST_IDLE;
      end
      ST_KEYOK:  if (pin_rise) nxt = ST_SETTLE;
      ST_SETTLE: begin
        if (pin_fall)      nxt = ST_IDLE;
        else if (tmr_done) nxt = ST_ACTIVE;
      end
      ST_ACTIVE: if (pin_fall) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  logic go_active;
  assign go_active = (nxt == ST_ACTIVE) || w4;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      prog_active <= 1'b0;
      hiz_en      <= 1'b0;
      dat_strobe  <= 1'b0;
      dat_bit     <= 1'b0;
    end else begin
      state       <= nxt;
      prog_active <= go_active;
      hiz_en      <= go_active;
      dat_strobe  <= go_active && sclk_rise;
      dat_bit     <= dat_s;
    end
  end
endmodule

// File: rtl/keygate_chk.sv
module keygate_chk #(
  parameter int KEY_W = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          prog_active,
  input logic          hiz_en,
  input logic          dat_strobe,
  input logic          pin_fall,
  input logic          w4,
  input logic          tmr_done,
  input logic [CW-1:0] key_cnt
);
  // R8
  hiz_follow_chk: assert property (@(posedge clk) disable iff (rst)
    prog_active == hiz_en);

  // R6
  strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    dat_strobe |-> prog_active);

  // R5
  settle_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(prog_active) && !$past(w4)) |-> $past(tmr_done));

  // R7
  fall_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_fall && !w4) |=> !prog_active);

  // R11
  key_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    key_cnt <= CW'(KEY_W));
endmodule

bind keygate_entry keygate_chk #(.KEY_W(KEY_W), .CW(CW)) u_keygate_chk (
  .clk(clk), .rst(rst), .prog_active(prog_active), .hiz_en(hiz_en),
  .dat_strobe(dat_strobe), .pin_fall(pin_fall), .w4(w4),
  .tmr_done(tmr_done), .key_cnt(key_cnt)
);

// File: tb/test_keygate_entry.sv
module test_keygate_entry;
  localparam int S = 40;
  localparam logic [31:0] GOOD = 32'h4D434850;
  localparam int NV = 8;
  // {pulse, expect, nbits[5:0], key[31:0]}
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 1'b1, 6'd32, 32'h4D434850},
    {1'b1, 1'b0, 6'd32, 32'h4D434851},
    {1'b1, 1'b0, 6'd32, 32'hCD434850},
    {1'b1, 1'b0, 6'd32, 32'h0A12C2B2},
    {1'b0, 1'b0, 6'd32, 32'h4D434850},
    {1'b1, 1'b0, 6'd31, 32'h4D434850},
    {1'b1, 1'b1, 6'd40, 32'h4D434850},
    {1'b1, 1'b0, 6'd32, 32'h00000000}
  };
  localparam string TAG [NV] = '{"R2", "R3", "R3", "R3", "R4", "R10", "R11", "R3"};

  logic clk = 0, rst = 1;
  logic tgt_rst_n = 0, ser_clk = 0, ser_dat = 0, wire4_sel = 0;
  logic prog_active, hiz_en, dat_strobe, dat_bit;
  int errors = 0, checks = 0, scnt = 0;
  logic sbit = 0;

  always #2 clk = ~clk;

  keygate_entry #(.SETTLE_CYC(S)) i_keygate_entry (
    .clk(clk), .rst(rst), .tgt_rst_n(tgt_rst_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .wire4_sel(wire4_sel), .prog_active(prog_active),
    .hiz_en(hiz_en), .dat_strobe(dat_strobe), .dat_bit(dat_bit)
  );

  always @(posedge clk) if (!rst && dat_strobe) begin
    scnt <= scnt + 1;
    sbit <= dat_bit;
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ser_bit(logic b);
    ser_dat = b;
    cyc(4);
    ser_clk = 1;
    cyc(4);
    ser_clk = 0;
    cyc(4);
  endtask

  task automatic sys_reset();
    rst = 1;
    cyc(3);
    rst = 0;
    cyc(4);
  endtask

  task automatic send_key(logic [31:0] key, int n);
    for (int i = 0; i < n; i++) ser_bit(i < 32 ? key[31-i] : 1'b1);
  endtask

  task automatic pulse();
    tgt_rst_n = 1;
    cyc(8);
    tgt_rst_n = 0;
    cyc(8);
  endtask

  initial begin
    cyc(4);
    rst = 0;
    cyc(1);
    // R1 reset state
    chk("R1 prog_active", prog_active, 1'b0);
    chk("R1 hiz_en", hiz_en, 1'b0);
    chk("R1 dat_strobe", dat_strobe, 1'b0);

    for (int k = 0; k < NV; k++) begin
      sys_reset();
      if (VEC[k][39]) pulse();
      send_key(VEC[k][31:0], int'(VEC[k][37:32]));
      cyc(8);
      tgt_rst_n = 1;
      cyc(S + 10);
      chk(TAG[k], prog_active, VEC[k][38]);
      chk("R8 vector", hiz_en, VEC[k][38]);
      tgt_rst_n = 0;
      cyc(8);
    end

    // R5 settle window, R6 no strobe during settle
    sys_reset();
    pulse();
    send_key(GOOD, 32);
    cyc(8);
    begin
      int base;
      base = scnt;
      tgt_rst_n = 1;
      ser_bit(1'b1);
      chk_int("R6 settle strobe", scnt - base, 0);
      cyc(S + 1 - 12);
      chk("R5 early", prog_active, 1'b0);
      cyc(3);
      chk("R5 due", prog_active, 1'b1);
      chk("R8 active", hiz_en, 1'b1);
      // R6 active strobes
      ser_bit(1'b1);
      chk_int("R6 strobe count 1", scnt - base, 1);
      chk("R6 bit one", sbit, 1'b1);
      ser_bit(1'b0);
      chk_int("R6 strobe count 2", scnt - base, 2);
      chk("R6 bit zero", sbit, 1'b0);
      // R7 drop on fall
      tgt_rst_n = 0;
      cyc(6);
      chk("R7 drop", prog_active, 1'b0);
      chk("R8 drop", hiz_en, 1'b0);
      tgt_rst_n = 1;
      cyc(S + 10);
      chk("R7 no reentry", prog_active, 1'b0);
      ser_bit(1'b1);
      chk_int("R7 no strobe", scnt - base, 2);
      // R9 four-wire
      wire4_sel = 1;
      cyc(6);
      chk("R9 active", prog_active, 1'b1);
      ser_bit(1'b1);
      chk_int("R9 strobe", scnt - base, 3);
      wire4_sel = 0;
      cyc(6);
      chk("R9 release", prog_active, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule